// File: doc/BRIEF.md
# Soft-Ramped Pseudo-Log Volume Stage

This block scales one channel of 24-bit signed audio samples ahead of a DAC modulator. A 7-bit volume code is expanded into a 13-bit linear gain level. The applied level does not jump to a new value. It walks toward the expanded target by one level per sample strobe, so changing the volume never produces a step in the output.

A separate soft-mute control drives a second gain counter. This counter counts down to zero while mute is requested and back up to unity when the request is released. It reverses at once from wherever it stands. Both gains are multiplied onto the sample in cascade, then rounded back to 24 bits.

A hold input represents a DAC reset or power-down. It clears the applied level immediately. Once the hold is released, the level fades in again toward whatever code is presented at that time.

Top module: `vol_ramp_stage`

## Requirements
- R1: After rst_n is low, level_out is 0, mute_gain_out is 1024 (unity), and sample_out is 0.
- R2: The target level for code c is ((2*l+33) << m) - 33, where m is c[6:4] and l is c[3:0]. Code 127 gives 8031, code 1 gives 2, code 126 gives 7775 and code 0 gives 0.
- R3: On each cycle with sample_stb high and dac_hold low, level_out moves by exactly one toward the target. It holds once it equals the target. Without a strobe it does not change.
- R4: While dac_hold is high, level_out is 0 from the cycle after dac_hold rises. After release, level_out ramps by one per strobe toward the current code's target.
- R5: With mute_req high, each strobe lowers mute_gain_out by one down to 0. With mute_req low, each strobe raises it by one up to 1024. A release partway through the ramp reverses the ramp from its current value.
- R6: The mute counter and the volume level evolve independently: code changes do not alter mute_gain_out, and mute_req does not alter level_out.
- R7: On a strobe, sample_out becomes sign(x)*floor((|x|*L*G + U/2)/U). Here x is sample_in, L and G are the level_out and mute_gain_out values present before that strobe, and U = 8031*1024. Between strobes sample_out holds.
- R8: With L = 8031 and G = 1024, sample_out equals sample_in, including the extreme values 8388607 and -8388608.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dac_hold | input | 1 | DAC reset/power-down: forces the level to zero |
| sample_stb | input | 1 | One-cycle pulse per audio sample period |
| vol_code | input | 7 | Volume code (127 = 0 dB, 0 = mute) |
| mute_req | input | 1 | Soft-mute request |
| sample_in | input | 24 | Signed input sample |
| sample_out | output | 24 | Signed scaled output sample |
| level_out | output | 13 | Applied linear volume level |
| mute_gain_out | output | 11 | Soft-mute gain counter (1024 = unity) |

## Verification
The bench first sweeps all 128 codes upward and checks every single-level step and every endpoint against the formula. A wrong exponent/mantissa split or offset would land on the wrong plateau; a slew that jumped or stepped by two would break the per-strobe delta count. It then ramps the full range down to code 0, asserts the hold mid-ramp, and reverses a partial mute to catch a counter that restarts instead of turning around. Output samples at unity, at mid-ramp gains and at full mute are compared with the rounding rule, so a truncating or mis-normalised multiplier gives off-by-one or scaled results.

// File: rtl/vol_pkg.sv
package vol_pkg;
    parameter int unsigned CODE_EXP_W  = 3;
    parameter int unsigned CODE_MANT_W = 4;
    parameter int unsigned SAMPLE_W    = 24;
    parameter int unsigned MUTE_STEPS  = 1024;

    typedef enum logic [1:0] {
        SLEW_STAY = 2'd0,
        SLEW_UP   = 2'd1,
        SLEW_DOWN = 2'd2
    } slew_dir_e;
endpackage

// File: rtl/vol_code_map.sv
module vol_code_map #(
    parameter int unsigned EXP_W  = vol_pkg::CODE_EXP_W,
    parameter int unsigned MANT_W = vol_pkg::CODE_MANT_W,
    parameter int unsigned LVL_W  = 13
) (
    input  logic [EXP_W+MANT_W-1:0] code_i,
    output logic [LVL_W-1:0]        target_o
);
    localparam int unsigned OFFSET = (1 << (MANT_W + 1)) + 1;
    localparam logic [LVL_W:0] OFF_V = (LVL_W+1)'(OFFSET);

    logic [MANT_W-1:0] mant_v;
    logic [EXP_W-1:0]  exp_v;
    logic [LVL_W:0]    base_v;
    logic [LVL_W:0]    shifted_v;

    // linear level = ((2*mantissa + offset) << exponent) - offset
    always_comb begin
        mant_v    = code_i[MANT_W-1:0];
        exp_v     = code_i[EXP_W+MANT_W-1:MANT_W];
        base_v    = ((LVL_W+1)'(mant_v) << 1) + OFF_V;
        shifted_v = base_v << exp_v;
        target_o  = LVL_W'(shifted_v - OFF_V);
    end
endmodule

// File: rtl/vol_slew.sv
module vol_slew #(
    parameter int unsigned LVL_W   = 13,
    parameter int unsigned LVL_MAX = 8031
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hold_i,
    input  logic             stb_i,
    input  logic [LVL_W-1:0] target_i,
    output logic [LVL_W-1:0] level_o
);
    import vol_pkg::*;

    typedef struct packed {
        logic [LVL_W-1:0] level;
    } slew_st_t;

    slew_st_t  st_d, st_q;
    slew_dir_e dir_v;

    always_comb begin
        st_d = st_q;
        if (st_q.level < target_i)      dir_v = SLEW_UP;
        else if (st_q.level > target_i) dir_v = SLEW_DOWN;
        else                            dir_v = SLEW_STAY;

        if (hold_i) begin
            st_d.level = '0;
        end else if (stb_i) begin
            case (dir_v)
                SLEW_UP:   st_d.level = st_q.level + 1'b1;
                SLEW_DOWN: st_d.level = st_q.level - 1'b1;
                default:   st_d.level = st_q.level;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign level_o = st_q.level;

    a_r4_hold_zero: assert property (@(posedge clk) disable iff (!rst_n)
        hold_i |=> (level_o == '0));
    a_r3_no_strobe_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold_i && !stb_i) |=> $stable(level_o));
    a_r3_single_step_up: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold_i && stb_i && level_o < target_i) |=> (level_o == $past(level_o) + 1'b1));
    a_r3_level_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        level_o <= LVL_W'(LVL_MAX));
endmodule

// File: rtl/mute_ramp.sv
module mute_ramp #(
    parameter int unsigned STEPS = vol_pkg::MUTE_STEPS,
    parameter int unsigned CNT_W = $clog2(STEPS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             stb_i,
    input  logic             mute_i,
    output logic [CNT_W-1:0] gain_o
);
    localparam logic [CNT_W-1:0] TOP = CNT_W'(STEPS);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } ramp_st_t;

    ramp_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (stb_i) begin
            if (mute_i && st_q.cnt != '0)      st_d.cnt = st_q.cnt - 1'b1;
            else if (!mute_i && st_q.cnt < TOP) st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{cnt: TOP};
        else        st_q <= st_d;
    end

    assign gain_o = st_q.cnt;

    a_r5_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        gain_o <= TOP);
    a_r5_no_strobe_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !stb_i |=> $stable(gain_o));
    a_r5_falls_by_one: assert property (@(posedge clk) disable iff (!rst_n)
        (stb_i && mute_i && gain_o != '0) |=> (gain_o == $past(gain_o) - 1'b1));
    a_r5_rises_by_one: assert property (@(posedge clk) disable iff (!rst_n)
        (stb_i && !mute_i && gain_o != TOP) |=> (gain_o == $past(gain_o) + 1'b1));
endmodule

// File: rtl/gain_apply.sv
module gain_apply #(
    parameter int unsigned SAMPLE_W = vol_pkg::SAMPLE_W,
    parameter int unsigned LVL_W    = 13,
    parameter int unsigned CNT_W    = 11,
    parameter int unsigned LVL_MAX  = 8031,
    parameter int unsigned STEPS    = vol_pkg::MUTE_STEPS
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                stb_i,
    input  logic [SAMPLE_W-1:0] sample_i,
    input  logic [LVL_W-1:0]    level_i,
    input  logic [CNT_W-1:0]    mgain_i,
    output logic [SAMPLE_W-1:0] sample_o
);
    localparam int unsigned PROD_W = SAMPLE_W + LVL_W + CNT_W;
    localparam logic [PROD_W-1:0] UNITY = PROD_W'(LVL_MAX) * PROD_W'(STEPS);
    localparam logic [PROD_W-1:0] HALF  = UNITY >> 1;
    localparam logic [PROD_W-1:0] POS_LIM = (PROD_W'(1) << (SAMPLE_W - 1)) - 1'b1;
    localparam logic [PROD_W-1:0] NEG_LIM = PROD_W'(1) << (SAMPLE_W - 1);

    typedef struct packed {
        logic [SAMPLE_W-1:0] out;
    } app_st_t;

    app_st_t st_d, st_q;

    logic                neg_v;
    logic [SAMPLE_W-1:0] mag_v;
    logic [PROD_W-1:0]   num_v;
    logic [PROD_W-1:0]   quo_v;

    always_comb begin
        st_d  = st_q;
        neg_v = sample_i[SAMPLE_W-1];
        mag_v = neg_v ? (~sample_i + 1'b1) : sample_i;
        num_v = PROD_W'(mag_v) * PROD_W'(level_i) * PROD_W'(mgain_i) + HALF;
        quo_v = num_v / UNITY;
        if (neg_v) begin
            if (quo_v > NEG_LIM) quo_v = NEG_LIM;
        end else begin
            if (quo_v > POS_LIM) quo_v = POS_LIM;
        end
        if (stb_i) begin
            st_d.out = neg_v ? (~SAMPLE_W'(quo_v) + 1'b1) : SAMPLE_W'(quo_v);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sample_o = st_q.out;

    a_r7_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
        !stb_i |=> $stable(sample_o));
    a_r7_zero_gain: assert property (@(posedge clk) disable iff (!rst_n)
        (stb_i && (level_i == '0 || mgain_i == '0)) |=> (sample_o == '0));
    a_r8_unity_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (stb_i && level_i == LVL_W'(LVL_MAX) && mgain_i == CNT_W'(STEPS))
        |=> (sample_o == $past(sample_i)));
endmodule

// File: rtl/vol_ramp_stage.sv
module vol_ramp_stage #(
    parameter int unsigned EXP_W    = vol_pkg::CODE_EXP_W,
    parameter int unsigned MANT_W   = vol_pkg::CODE_MANT_W,
    parameter int unsigned SAMPLE_W = vol_pkg::SAMPLE_W,
    parameter int unsigned STEPS    = vol_pkg::MUTE_STEPS,
    parameter int unsigned CODE_W   = EXP_W + MANT_W,
    parameter int unsigned LVL_MAX  = (((1 << (MANT_W + 1)) - 2 + (1 << (MANT_W + 1)) + 1)
                                       << ((1 << EXP_W) - 1)) - ((1 << (MANT_W + 1)) + 1),
    parameter int unsigned LVL_W    = $clog2(LVL_MAX + 1),
    parameter int unsigned CNT_W    = $clog2(STEPS + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                dac_hold,
    input  logic                sample_stb,
    input  logic [CODE_W-1:0]   vol_code,
    input  logic                mute_req,
    input  logic [SAMPLE_W-1:0] sample_in,
    output logic [SAMPLE_W-1:0] sample_out,
    output logic [LVL_W-1:0]    level_out,
    output logic [CNT_W-1:0]    mute_gain_out
);
    logic [LVL_W-1:0] target_w;

    vol_code_map #(.EXP_W(EXP_W), .MANT_W(MANT_W), .LVL_W(LVL_W)) u_map (
        .code_i   (vol_code),
        .target_o (target_w)
    );

    vol_slew #(.LVL_W(LVL_W), .LVL_MAX(LVL_MAX)) u_slew (
        .clk      (clk),
        .rst_n    (rst_n),
        .hold_i   (dac_hold),
        .stb_i    (sample_stb),
        .target_i (target_w),
        .level_o  (level_out)
    );

    mute_ramp #(.STEPS(STEPS), .CNT_W(CNT_W)) u_mute (
        .clk    (clk),
        .rst_n  (rst_n),
        .stb_i  (sample_stb),
        .mute_i (mute_req),
        .gain_o (mute_gain_out)
    );

    gain_apply #(
        .SAMPLE_W (SAMPLE_W),
        .LVL_W    (LVL_W),
        .CNT_W    (CNT_W),
        .LVL_MAX  (LVL_MAX),
        .STEPS    (STEPS)
    ) u_apply (
        .clk      (clk),
        .rst_n    (rst_n),
        .stb_i    (sample_stb),
        .sample_i (sample_in),
        .level_i  (level_out),
        .mgain_i  (mute_gain_out),
        .sample_o (sample_out)
    );

    a_r2_code_zero_reaches_mute: assert property (@(posedge clk) disable iff (!rst_n)
        (vol_code == '0 && !dac_hold && sample_stb && level_out == LVL_W'(1))
        |=> (level_out == '0));
    a_r6_code_leaves_mute: assert property (@(posedge clk) disable iff (!rst_n)
        (!sample_stb) |=> $stable(mute_gain_out));
endmodule

// File: tb/vol_ramp_stage_bench.sv
module vol_ramp_stage_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        dac_hold = 1'b0;
    logic        sample_stb = 1'b0;
    logic [6:0]  vol_code = '0;
    logic        mute_req = 1'b0;
    logic [23:0] sample_in = '0;
    logic [23:0] sample_out;
    logic [12:0] level_out;
    logic [10:0] mute_gain_out;

    int checks = 0;
    int errors = 0;
    int exp_lvl;
    int exp_m;

    always #2 clk = ~clk;

    vol_ramp_stage u_vol_ramp_stage (
        .clk           (clk),
        .rst_n         (rst_n),
        .dac_hold      (dac_hold),
        .sample_stb    (sample_stb),
        .vol_code      (vol_code),
        .mute_req      (mute_req),
        .sample_in     (sample_in),
        .sample_out    (sample_out),
        .level_out     (level_out),
        .mute_gain_out (mute_gain_out)
    );

    function automatic int tgt(input int c);
        int m, l;
        m = (c >> 4) & 7;
        l = c & 15;
        return ((2 * l + 33) << m) - 33;
    endfunction

    function automatic longint exp_out(input longint x, input longint lv, input longint mg);
        longint mag, q;
        mag = (x < 0) ? -x : x;
        q = (mag * lv * mg + (8031 * 1024) / 2) / (8031 * 1024);
        return (x < 0) ? -q : q;
    endfunction

    task automatic chk(input string req, input longint act, input longint expv);
        checks++;
        if (act != expv) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, expv);
        end
    endtask

    task automatic pulse(input longint d);
        sample_in  = 24'(d);
        sample_stb = 1'b1;
        @(posedge clk); #1;
        sample_stb = 1'b0;
    endtask

    // one strobe against the running models of level and mute gain
    task automatic model_pulse(input longint d, inout int bad_l, inout int bad_m, inout int bad_o);
        longint eo;
        int t;
        eo = exp_out(d, exp_lvl, exp_m);
        pulse(d);
        t = tgt(int'(vol_code));
        if (exp_lvl < t) exp_lvl++;
        else if (exp_lvl > t) exp_lvl--;
        if (mute_req && exp_m > 0) exp_m--;
        else if (!mute_req && exp_m < 1024) exp_m++;
        if (int'(level_out) != exp_lvl) bad_l++;
        if (int'(mute_gain_out) != exp_m) bad_m++;
        if (longint'($signed(sample_out)) != eo) bad_o++;
    endtask

    initial begin
        repeat (1500000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual 0 expected 1");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int prev, bad, lv, mg, bl, bm, bo;
        longint d, held;
        repeat (4) @(posedge clk); #1;
        chk("R1 level at reset", level_out, 0);
        chk("R1 mute gain at reset", mute_gain_out, 1024);
        chk("R1 sample at reset", sample_out, 0);
        rst_n = 1'b1;
        @(posedge clk); #1;

        // R2/R3: upward sweep through every code
        prev = 0;
        for (int c = 1; c < 128; c++) begin
            vol_code = 7'(c);
            bad = 0;
            for (int k = 0; k < tgt(c) - prev; k++) begin
                lv = level_out;
                pulse(0);
                if (int'(level_out) != lv + 1) bad++;
            end
            chk("R3 one level per strobe upward", bad, 0);
            chk("R2 plateau level for code", level_out, tgt(c));
            lv = level_out; mg = mute_gain_out;
            d = (c % 2 == 1) ? -(longint'(c) * 65537) : longint'(c) * 60013;
            pulse(d);
            chk("R3 level holds at target", level_out, tgt(c));
            chk("R7 scaled sample", longint'($signed(sample_out)), exp_out(d, lv, mg));
            prev = tgt(c);
        end
        chk("R2 code 127 level", level_out, 8031);

        // R8 unity pass-through
        pulse(8388607);
        chk("R8 unity max", longint'($signed(sample_out)), 8388607);
        pulse(-8388608);
        chk("R8 unity min", longint'($signed(sample_out)), -8388608);
        pulse(12345);
        chk("R8 unity mid", longint'($signed(sample_out)), 12345);

        // R7 hold between strobes
        held = longint'($signed(sample_out));
        sample_in = 24'h3ABCDE;
        repeat (3) @(posedge clk); #1;
        chk("R7 output holds without strobe", longint'($signed(sample_out)), held);

        // downward ramp to code 0
        vol_code = 7'd0;
        bad = 0;
        for (int k = 0; k < 8031; k++) begin
            lv = level_out;
            pulse(0);
            if (int'(level_out) != lv - 1) bad++;
        end
        chk("R3 one level per strobe downward", bad, 0);
        chk("R2 code 0 level", level_out, 0);
        pulse(-5000000);
        chk("R2 code 0 stays at zero", level_out, 0);
        chk("R7 zero level gives zero out", sample_out, 0);

        // R3 no strobe, no movement
        vol_code = 7'd127;
        repeat (5) @(posedge clk); #1;
        chk("R3 no change without strobe", level_out, 0);

        // R4 hold
        repeat (100) pulse(0);
        chk("R4 ramp before hold", level_out, 100);
        dac_hold = 1'b1;
        @(posedge clk); #1;
        chk("R4 hold clears level", level_out, 0);
        repeat (3) pulse(7);
        chk("R4 level stays zero while held", level_out, 0);
        dac_hold = 1'b0;
        repeat (50) pulse(0);
        chk("R4 fade in after release", level_out, 50);
        repeat (7981) pulse(0);
        chk("R4 fade in reaches current code", level_out, 8031);

        // R5/R6 mute with reversal while the volume also moves
        exp_lvl = level_out; exp_m = mute_gain_out;
        bl = 0; bm = 0; bo = 0;
        mute_req = 1'b1;
        for (int k = 0; k < 300; k++) model_pulse((k % 2 == 1) ? -longint'(k * 27961) : longint'(k * 27961), bl, bm, bo);
        chk("R5 partial mute count", mute_gain_out, 724);
        mute_req = 1'b0;
        vol_code = 7'd120;
        for (int k = 0; k < 300; k++) model_pulse(longint'(8000000 - k * 911), bl, bm, bo);
        chk("R5 reversal back to unity", mute_gain_out, 1024);
        chk("R6 level ramps independently of mute", level_out, 8031 - 300);
        mute_req = 1'b1;
        for (int k = 0; k < 1100; k++) model_pulse(-longint'(k * 7001), bl, bm, bo);
        chk("R5 full mute reaches zero", mute_gain_out, 0);
        chk("R7 full mute gives zero out", sample_out, 0);
        vol_code = 7'd127;
        mute_req = 1'b0;
        for (int k = 0; k < 1100; k++) model_pulse(longint'(k * 7603) - 4000000, bl, bm, bo);
        chk("R5 release restores unity", mute_gain_out, 1024);
        chk("R6 level tracked during mute", bl, 0);
        chk("R5 mute count tracked per strobe", bm, 0);
        chk("R7 outputs during ramps", bo, 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule